// File: doc/BRIEF.md
# Search-Coprocessor SRAM Write Pass-Through

This block lives inside a search coprocessor. It watches the host command bus (an 11-bit command field with a valid strobe) and the 72-bit data bus for a two-cycle SRAM write. When the write is addressed to this device and lands in the SRAM address space, it builds a 24-bit external SRAM address and a 72-bit data word. It then replays the write on an external SRAM port.

The replay is not immediate. The accepted write travels through a fixed delay line. It therefore reaches the SRAM bus with the same latency that a search result would have, counted from the second command cycle. Writes carrying the burst bit are refused and reported on a one-cycle error flag. The two bus cycles that follow a command are ignored, so a new command can start at most once every four cycles.

Top module: `srw_passthru`

## Requirements
- R1: While reset is held and on the first cycle after it, `sram_ce_n`, `sram_we_n` and `sram_ale_n` are 1, and `sram_dq_oe` and `burst_err` are 0.
- R2: A write is two consecutive cycles with `cmd_vld`=1 and `cmd[1:0]`=2'b01 (first cycle A, second cycle B). If cycle B lacks `cmd_vld` or carries another opcode, the command is dropped and no SRAM cycle results.
- R3: A write whose cycle-A `dq[20:19]` is not 2'b10 produces no SRAM cycle and no error flag.
- R4: A write whose cycle-A `dq[25:21]` differs from `dev_id` produces no SRAM cycle and no error flag.
- R5: The SRAM address is {cycle-A `cmd[8:6]`, cycle-B `cmd[4:3]`, cycle-A `dq[18:0]`}, most significant first. The SRAM data is the cycle-B `dq`.
- R6: A targeted write with cycle-A `cmd[2]`=1 is not executed. `burst_err` is 1 for exactly the one cycle after the clock edge that samples cycle B.
- R7: If the clock edge that samples cycle B is edge k, then `sram_ce_n`, `sram_we_n` and `sram_ale_n` are 0 only between edges k+LAT_CYC and k+LAT_CYC+1. In that same cycle `sram_dq_oe` is 1 and the address and data of R5 are driven.
- R8: The two cycles after cycle B are ignored, even if they carry a valid write opcode. The next command may begin on the fourth cycle counted from cycle A.
- R9: Writes spaced four cycles apart each produce their own one-cycle SRAM write, in order, with the latency of R7, even while an earlier write is still in the delay line.
- R10: Outside the SRAM write cycle, the strobes stay 1 and `sram_dq_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_id | input | 5 | Static identity of this device |
| cmd | input | 11 | Host command field |
| cmd_vld | input | 1 | Command field valid |
| dq | input | 72 | Host data/address bus |
| sram_addr | output | 24 | External SRAM address |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_ale_n | output | 1 | Address-latch strobe, active low |
| sram_dq | output | 72 | SRAM write data |
| sram_dq_oe | output | 1 | Output enable for `sram_dq` |
| burst_err | output | 1 | Burst write refused, one-cycle pulse |

## Verification
The bench builds the block with LAT_CYC = 5. This is longer than the four-cycle command spacing, so two accepted writes sit in the delay line at once. Back-to-back traffic therefore exercises ordering and overlap in the pipeline, not only single-write timing. Gap cycles that carry a fully targeted write opcode probe the ignore window. A dropped cycle B probes the framing.

// File: rtl/srw_pkg.sv
package srw_pkg;
  localparam int DQ_W   = 72;
  localparam int CMD_W  = 11;
  localparam int ID_W   = 5;
  localparam int SADR_W = 24;
  localparam int LO_W   = 19;

  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] SPACE_SRAM = 2'b10;

  typedef struct packed {
    logic              vld;
    logic [SADR_W-1:0] addr;
    logic [DQ_W-1:0]   data;
  } wr_rec_t;

  typedef enum logic [1:0] {ST_IDLE, ST_PHB, ST_GAP1, ST_GAP2} dec_st_e;

  function automatic logic is_write_op(input logic vld, input logic [CMD_W-1:0] c);
    return vld && (c[1:0] == OP_WRITE);
  endfunction

  function automatic logic targets_me(input logic [DQ_W-1:0] d, input logic [ID_W-1:0] id);
    return (d[20:19] == SPACE_SRAM) && (d[25:21] == id);
  endfunction

  function automatic logic [SADR_W-1:0] build_addr(input logic [2:0] hi,
                                                   input logic [1:0] mid,
                                                   input logic [LO_W-1:0] lo);
    return {hi, mid, lo};
  endfunction
endpackage

// File: rtl/srw_decode.sv
module srw_decode
  import srw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ID_W-1:0]  dev_id,
  input  logic [CMD_W-1:0] cmd,
  input  logic             cmd_vld,
  input  logic [DQ_W-1:0]  dq,
  output wr_rec_t          wr_rec,
  output logic             wr_fire,
  output logic             burst_err
);
  dec_st_e         st_q, st_d;
  logic [2:0]      a_hi_q;
  logic [LO_W-1:0] a_lo_q;
  logic            a_hit_q, a_burst_q;
  logic            op_ok, phb_ok, berr_d;

  assign op_ok  = is_write_op(cmd_vld, cmd);
  assign phb_ok = (st_q == ST_PHB) && op_ok;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (op_ok) st_d = ST_PHB;
      ST_PHB:  st_d = op_ok ? ST_GAP1 : ST_IDLE;
      ST_GAP1: st_d = ST_GAP2;
      ST_GAP2: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign wr_fire = phb_ok && a_hit_q && !a_burst_q;
  assign berr_d  = phb_ok && a_hit_q && a_burst_q;

  always_comb begin
    wr_rec.vld  = wr_fire;
    wr_rec.addr = build_addr(a_hi_q, cmd[4:3], a_lo_q);
    wr_rec.data = dq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      a_hi_q    <= '0;
      a_lo_q    <= '0;
      a_hit_q   <= 1'b0;
      a_burst_q <= 1'b0;
      burst_err <= 1'b0;
    end else begin
      st_q      <= st_d;
      burst_err <= berr_d;
      if (st_q == ST_IDLE && op_ok) begin
        a_hi_q    <= cmd[8:6];
        a_lo_q    <= dq[LO_W-1:0];
        a_hit_q   <= targets_me(dq, dev_id);
        a_burst_q <= cmd[2];
      end
    end
  end

  assert_gap_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_fire ##1 !wr_fire ##1 !wr_fire);

  assert_burst_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_err |=> !burst_err);

  assert_burst_noexec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_err |-> !$past(wr_fire));
endmodule

// File: rtl/srw_delay.sv
module srw_delay
  import srw_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  wr_rec_t din,
  output wr_rec_t dout
);
  wr_rec_t [DEPTH-1:0] stg;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg[0] <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg <= '0;
        end else begin
          stg[0] <= din;
          for (int i = 1; i < int'(DEPTH); i++) stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign dout = stg[DEPTH-1];

  assert_tail_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dout.vld |=> !dout.vld);
endmodule

// File: rtl/srw_port.sv
module srw_port
  import srw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  wr_rec_t           rec,
  output logic [SADR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_ale_n,
  output logic [DQ_W-1:0]   sram_dq,
  output logic              sram_dq_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_addr  <= '0;
      sram_dq    <= '0;
      sram_ce_n  <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_ale_n <= 1'b1;
      sram_dq_oe <= 1'b0;
    end else begin
      sram_ce_n  <= !rec.vld;
      sram_we_n  <= !rec.vld;
      sram_ale_n <= !rec.vld;
      sram_dq_oe <= rec.vld;
      if (rec.vld) begin
        sram_addr <= rec.addr;
        sram_dq   <= rec.data;
      end
    end
  end

  assert_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |=> sram_ce_n && !sram_dq_oe);
endmodule

// File: rtl/srw_passthru.sv
module srw_passthru
  import srw_pkg::*;
#(
  parameter int unsigned LAT_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   dev_id,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              cmd_vld,
  input  logic [DQ_W-1:0]   dq,
  output logic [SADR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_ale_n,
  output logic [DQ_W-1:0]   sram_dq,
  output logic              sram_dq_oe,
  output logic              burst_err
);
  localparam int unsigned OUT_LAT = LAT_CYC + 1;

  wr_rec_t wr_rec, tail_rec;
  logic    wr_fire;

  srw_decode u_decode (
    .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .cmd(cmd), .cmd_vld(cmd_vld),
    .dq(dq), .wr_rec(wr_rec), .wr_fire(wr_fire), .burst_err(burst_err)
  );

  srw_delay #(.DEPTH(LAT_CYC)) u_delay (
    .clk(clk), .rst_n(rst_n), .din(wr_rec), .dout(tail_rec)
  );

  srw_port u_port (
    .clk(clk), .rst_n(rst_n), .rec(tail_rec), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_ale_n(sram_ale_n),
    .sram_dq(sram_dq), .sram_dq_oe(sram_dq_oe)
  );

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> ##(OUT_LAT) !sram_ce_n);

  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> $past(wr_fire, OUT_LAT));

  assert_addr_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> (sram_addr == $past(wr_rec.addr, OUT_LAT)) &&
                   (sram_dq == $past(wr_rec.data, OUT_LAT)));
endmodule

// File: tb/tb_srw_passthru.sv
module tb_srw_passthru;
  localparam int TB_LAT = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  dev_id = 5'h0B;
  logic [10:0] cmd = '0;
  logic        cmd_vld = 1'b0;
  logic [71:0] dq = '0;
  logic [23:0] sram_addr;
  logic        sram_ce_n, sram_we_n, sram_ale_n, sram_dq_oe, burst_err;
  logic [71:0] sram_dq;

  always #2 clk = ~clk;

  srw_passthru #(.LAT_CYC(TB_LAT)) dut (
    .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .cmd(cmd), .cmd_vld(cmd_vld),
    .dq(dq), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_ale_n(sram_ale_n), .sram_dq(sram_dq), .sram_dq_oe(sram_dq_oe),
    .burst_err(burst_err)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  task automatic check(input string t, input string what, input logic [95:0] act,
                       input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  // Behavioural reference model
  typedef struct { int due; logic [23:0] a; logic [71:0] d; } ev_t;
  ev_t        q[$];
  int         edge_n = 0;
  int         mst = 0;
  logic [10:0] m_cmd_a;
  logic [71:0] m_dq_a;
  logic        berr_exp = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); mst = 0; berr_exp = 1'b0; edge_n = 0;
    end else begin
      berr_exp = 1'b0;
      case (mst)
        0: if (cmd_vld && cmd[1:0] == 2'b01) begin
             m_cmd_a = cmd; m_dq_a = dq; mst = 1;
           end
        1: if (cmd_vld && cmd[1:0] == 2'b01) begin
             if (m_dq_a[20:19] == 2'b10 && m_dq_a[25:21] == dev_id) begin
               if (m_cmd_a[2]) berr_exp = 1'b1;
               else begin
                 ev_t e;
                 e.due = edge_n + TB_LAT;
                 e.a = {m_cmd_a[8:6], cmd[4:3], m_dq_a[18:0]};
                 e.d = dq;
                 q.push_back(e);
               end
             end
             mst = 2;
           end else mst = 0;
        2: mst = 3;
        default: mst = 0;
      endcase
      edge_n++;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && edge_n > 0) begin
      logic act_exp;
      act_exp = (q.size() > 0) && (q[0].due == edge_n - 1);
      check(tag, "ce_n", {95'b0, sram_ce_n}, {95'b0, !act_exp});
      check(tag, "we_n", {95'b0, sram_we_n}, {95'b0, !act_exp});
      check(tag, "ale_n", {95'b0, sram_ale_n}, {95'b0, !act_exp});
      check(tag, "dq_oe", {95'b0, sram_dq_oe}, {95'b0, act_exp});
      check(tag, "burst_err", {95'b0, burst_err}, {95'b0, berr_exp});
      if (act_exp) begin
        check(tag, "addr", {72'b0, sram_addr}, {72'b0, q[0].a});
        check(tag, "data", {24'b0, sram_dq}, {24'b0, q[0].d});
        void'(q.pop_front());
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cmd_vld = 1'b0; cmd = '0; dq = {3{24'hA5A5A5}};
    end
  endtask

  task automatic send_write(input logic [4:0] id, input logic [1:0] sp, input logic bst,
                            input logic [23:0] adr, input logic [71:0] dat,
                            input logic b_ok, input logic gap_op);
    @(negedge clk);
    cmd_vld = 1'b1;
    cmd = {2'b00, adr[23:21], 3'b000, bst, 2'b01};
    dq  = {dat[71:26], id, sp, adr[18:0]};
    @(negedge clk);
    cmd_vld = 1'b1;
    cmd = {2'b00, 3'b000, 1'b0, adr[20:19], 1'b0, (b_ok ? 2'b01 : 2'b10)};
    dq  = dat;
    for (int g = 0; g < 2; g++) begin
      @(negedge clk);
      cmd_vld = gap_op;
      cmd = {2'b00, ~adr[23:21], 3'b000, 1'b0, 2'b01};
      dq  = {~dat[71:26], dev_id, 2'b10, ~adr[18:0]};
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    check("R1", "ce_n", {95'b0, sram_ce_n}, 96'd1);
    check("R1", "we_n", {95'b0, sram_we_n}, 96'd1);
    check("R1", "ale_n", {95'b0, sram_ale_n}, 96'd1);
    check("R1", "dq_oe", {95'b0, sram_dq_oe}, 96'd0);
    check("R1", "burst_err", {95'b0, burst_err}, 96'd0);
    rst_n = 1'b1;
    idle(3);

    tag = "R5"; // single accepted write, address and data assembly
    send_write(5'h0B, 2'b10, 1'b0, 24'hABCDEF, 72'h12_3456_789A_BCDE_F012, 1'b1, 1'b0);
    idle(TB_LAT + 3);

    tag = "R7"; // latency, with the address at the extremes
    send_write(5'h0B, 2'b10, 1'b0, 24'hFFFFFF, {72{1'b1}}, 1'b1, 1'b0);
    idle(TB_LAT + 3);
    send_write(5'h0B, 2'b10, 1'b0, 24'h000000, 72'h0, 1'b1, 1'b0);
    idle(TB_LAT + 3);

    tag = "R4"; // wrong device id
    send_write(5'h0A, 2'b10, 1'b0, 24'h111111, 72'h1, 1'b1, 1'b0);
    send_write(5'h1B, 2'b10, 1'b0, 24'h222222, 72'h2, 1'b1, 1'b0);
    idle(TB_LAT + 3);

    tag = "R3"; // address space other than SRAM
    send_write(5'h0B, 2'b01, 1'b0, 24'h333333, 72'h3, 1'b1, 1'b0);
    send_write(5'h0B, 2'b11, 1'b0, 24'h444444, 72'h4, 1'b1, 1'b0);
    send_write(5'h0B, 2'b00, 1'b0, 24'h555555, 72'h5, 1'b1, 1'b0);
    idle(TB_LAT + 3);

    tag = "R6"; // burst bit set: refused and flagged
    send_write(5'h0B, 2'b10, 1'b1, 24'h666666, 72'h6, 1'b1, 1'b0);
    idle(TB_LAT + 3);

    tag = "R2"; // cycle B has wrong opcode
    send_write(5'h0B, 2'b10, 1'b0, 24'h777777, 72'h7, 1'b0, 1'b0);
    idle(TB_LAT + 3);

    tag = "R8"; // gap cycles carry a targeted write opcode, must be ignored
    send_write(5'h0B, 2'b10, 1'b0, 24'h0F0F0F, 72'hF0F0, 1'b1, 1'b1);
    idle(TB_LAT + 3);

    tag = "R9"; // four writes spaced four cycles apart, overlapping in the pipe
    for (int k = 0; k < 4; k++)
      send_write(5'h0B, 2'b10, 1'b0, 24'h100000 + 24'(k * 24'h010203),
                 72'hC0FFEE_0000 + 72'(k), 1'b1, 1'b0);
    idle(TB_LAT + 3);

    tag = "R10"; // mixed accepted and rejected traffic
    send_write(5'h0B, 2'b10, 1'b0, 24'h0ABCDE, 72'h55, 1'b1, 1'b0);
    send_write(5'h0C, 2'b10, 1'b0, 24'h0ABCDF, 72'h66, 1'b1, 1'b0);
    send_write(5'h0B, 2'b10, 1'b1, 24'h0ABCE0, 72'h77, 1'b1, 1'b0);
    send_write(5'h0B, 2'b10, 1'b0, 24'h0ABCE1, 72'h88, 1'b1, 1'b0);
    idle(TB_LAT + 4);

    check("R9", "events left in model", 96'(q.size()), 96'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule